// File: doc/BRIEF.md
# Parallel Port Direction and Polarity Register Bank

This block is the register core of a small parallel-port expander. It keeps three writable 8-bit registers and produces the direction and drive value of every port pin from them. The three registers are the latched output data, a polarity mask and a direction mask. A fourth, read-only view reports the pin levels. A serial front end, which is not part of this block, turns bus transactions into a register index plus a write strobe or a read strobe. It also passes in pin levels that have already been synchronised.

The input view always reports every pin, XORed with the polarity mask, whatever that pin's direction. The output register reads back its stored value, not the pin. A write aimed at the input view is dropped. Read data is registered on the read strobe, so the pin levels are sampled at the very edge that returns each byte. A pin switched from input to output drives whatever value the output register has held in the meantime.

Top module: `pxp_port_bank`

## Requirements
- R1: While `rst` is high at a clock edge, the output register becomes 0xFF, the polarity register 0x00, the direction register 0xFF and `rd_data` 0x00. So after reset `pin_oe` is 0x00 and `pin_out` is 0xFF.
- R2: The register index is encoded as 0 = input view, 1 = output data, 2 = polarity mask, 3 = direction mask. With `wr_en` high at an edge, the indexed register (1, 2 or 3) takes `wr_data` at that edge.
- R3: Direction bit n = 1 makes pin n an input (`pin_oe[n]` = 0). Direction bit n = 0 enables the driver (`pin_oe[n]` = 1).
- R4: A read of index 0 returns `pin_lvl ^ polarity`, using the pin levels present at the read edge, for all pins including those set as outputs.
- R5: A read of index 1 returns the stored output register, whatever the pin levels are.
- R6: A write to index 0 changes no register, no `pin_oe` bit and no `pin_out` bit.
- R7: `pin_out` equals the output register. It changes in the cycle after a write to index 1 and at no other time outside reset. The value is kept while a pin is an input and is driven as soon as that pin becomes an output.
- R8: `rd_data` changes only at an edge with `rd_en` high. A read and a write in the same cycle return the register value from before the write.
- R9: Raising `rst` during operation restores every register default in a single edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_idx | input | 2 | Register index for the read or write |
| wr_en | input | 1 | Write strobe |
| wr_data | input | WIDTH | Write data |
| rd_en | input | 1 | Read strobe; loads `rd_data` |
| pin_lvl | input | WIDTH | Synchronised pin levels |
| rd_data | output | WIDTH | Registered read data |
| pin_oe | output | WIDTH | Per-pin driver enable, 1 = drive |
| pin_out | output | WIDTH | Per-pin drive value |

## Verification
A reference model in the bench runs the register bank cycle by cycle. It is compared against all three outputs on every clock, through directed sequences and then a stretch of random traffic.

The directed patterns do the following:
- Mixed-polarity masks with pins high and low separate a true XOR from a pass-through or a constant inversion.
- Pins set as outputs that are held at levels differing from the output register show that the input view follows the pin and the output read follows the flop.
- Back-to-back direction flips around an output write separate a held value from one that was cleared.
- A same-cycle read and write exposes any forwarding of the new value.

// File: rtl/pxp_pkg.sv
package pxp_pkg;

    localparam int unsigned PORT_W = 8;

    typedef enum logic [1:0] {
        SEL_IN  = 2'd0,
        SEL_OUT = 2'd1,
        SEL_POL = 2'd2,
        SEL_DIR = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic to_out;
        logic to_pol;
        logic to_dir;
    } wr_hit_t;

    function automatic wr_hit_t decode_write(logic wr, reg_sel_e sel);
        wr_hit_t h;
        h.to_out = wr && (sel == SEL_OUT);
        h.to_pol = wr && (sel == SEL_POL);
        h.to_dir = wr && (sel == SEL_DIR);
        return h;
    endfunction

endpackage

// File: rtl/pxp_reg_store.sv
module pxp_reg_store
    import pxp_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_en,
    input  reg_sel_e     sel,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] out_q,
    output logic [W-1:0] pol_q,
    output logic [W-1:0] dir_q
);

    localparam logic [W-1:0] ONES  = '1;
    localparam logic [W-1:0] ZEROS = '0;

    wr_hit_t hit;
    assign hit = decode_write(wr_en, sel);

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q <= ONES;
            pol_q <= ZEROS;
            dir_q <= ONES;
        end else begin
            if (hit.to_out) out_q <= wr_data;
            if (hit.to_pol) pol_q <= wr_data;
            if (hit.to_dir) dir_q <= wr_data;
        end
    end

    assert_defaults_R1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (out_q == ONES && pol_q == ZEROS && dir_q == ONES));

    assert_write_lands_R2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && sel == SEL_POL) |=> (pol_q == $past(wr_data)));

    assert_idx0_ignored_R6: assert property (@(posedge clk) disable iff (rst)
        (wr_en && sel == SEL_IN) |=> ($stable(out_q) && $stable(pol_q) && $stable(dir_q)));

endmodule

// File: rtl/pxp_read_path.sv
module pxp_read_path
    import pxp_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         rd_en,
    input  reg_sel_e     sel,
    input  logic [W-1:0] pin_lvl,
    input  logic [W-1:0] out_q,
    input  logic [W-1:0] pol_q,
    input  logic [W-1:0] dir_q,
    output logic [W-1:0] rd_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q <= '0;
        end else if (rd_en) begin
            case (sel)
                SEL_IN:  rd_q <= pin_lvl ^ pol_q;
                SEL_OUT: rd_q <= out_q;
                SEL_POL: rd_q <= pol_q;
                default: rd_q <= dir_q;
            endcase
        end
    end

    assert_input_view_R4: assert property (@(posedge clk) disable iff (rst)
        (rd_en && sel == SEL_IN) |=> (rd_q == ($past(pin_lvl) ^ $past(pol_q))));

    assert_out_readback_R5: assert property (@(posedge clk) disable iff (rst)
        (rd_en && sel == SEL_OUT) |=> (rd_q == $past(out_q)));

    assert_read_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> $stable(rd_q));

endmodule

// File: rtl/pxp_pin_drive.sv
module pxp_pin_drive #(
    parameter int unsigned W = 8
) (
    input  logic [W-1:0] out_q,
    input  logic [W-1:0] dir_q,
    output logic [W-1:0] pin_oe,
    output logic [W-1:0] pin_out
);

    for (genvar b = 0; b < W; b++) begin : g_pin
        assign pin_oe[b]  = ~dir_q[b];
        assign pin_out[b] = out_q[b];
    end

endmodule

// File: rtl/pxp_port_bank.sv
module pxp_port_bank
    import pxp_pkg::*;
#(
    parameter int unsigned WIDTH = PORT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       reg_idx,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rd_en,
    input  logic [WIDTH-1:0] pin_lvl,
    output logic [WIDTH-1:0] rd_data,
    output logic [WIDTH-1:0] pin_oe,
    output logic [WIDTH-1:0] pin_out
);

    reg_sel_e         sel;
    logic [WIDTH-1:0] out_q;
    logic [WIDTH-1:0] pol_q;
    logic [WIDTH-1:0] dir_q;

    assign sel = reg_sel_e'(reg_idx);

    pxp_reg_store #(.W(WIDTH)) store_i (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .sel     (sel),
        .wr_data (wr_data),
        .out_q   (out_q),
        .pol_q   (pol_q),
        .dir_q   (dir_q)
    );

    pxp_read_path #(.W(WIDTH)) read_i (
        .clk     (clk),
        .rst     (rst),
        .rd_en   (rd_en),
        .sel     (sel),
        .pin_lvl (pin_lvl),
        .out_q   (out_q),
        .pol_q   (pol_q),
        .dir_q   (dir_q),
        .rd_q    (rd_data)
    );

    pxp_pin_drive #(.W(WIDTH)) drive_i (
        .out_q   (out_q),
        .dir_q   (dir_q),
        .pin_oe  (pin_oe),
        .pin_out (pin_out)
    );

    assert_dir_to_oe_R3: assert property (@(posedge clk) disable iff (rst)
        (wr_en && reg_idx == 2'd3) |=> (pin_oe == ~$past(wr_data)));

    assert_pin_out_write_R7: assert property (@(posedge clk) disable iff (rst)
        (wr_en && reg_idx == 2'd1) |=> (pin_out == $past(wr_data)));

    assert_pin_out_held_R7: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && reg_idx == 2'd1) |=> $stable(pin_out));

endmodule

// File: tb/pxp_port_bank_tb_top.sv
module pxp_port_bank_tb_top;

    logic       clk = 1'b0;
    logic       rst;
    logic [1:0] reg_idx;
    logic       wr_en;
    logic       rd_en;
    logic [7:0] wr_data;
    logic [7:0] pin_lvl;
    logic [7:0] rd_data;
    logic [7:0] pin_oe;
    logic [7:0] pin_out;

    always #5 clk = ~clk;

    pxp_port_bank #(.WIDTH(8)) dut_i (
        .clk     (clk),
        .rst     (rst),
        .reg_idx (reg_idx),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .rd_en   (rd_en),
        .pin_lvl (pin_lvl),
        .rd_data (rd_data),
        .pin_oe  (pin_oe),
        .pin_out (pin_out)
    );

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic [7:0] m_out, m_pol, m_dir, m_rd;

    task automatic chk(string tag, logic [7:0] act, logic [7:0] exp, string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%02h expected=%02h", tag, what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        if (rst) begin
            m_out = 8'hFF; m_pol = 8'h00; m_dir = 8'hFF; m_rd = 8'h00;
        end else begin
            if (rd_en) begin
                if (reg_idx == 2'd0)      m_rd = pin_lvl ^ m_pol;
                else if (reg_idx == 2'd1) m_rd = m_out;
                else if (reg_idx == 2'd2) m_rd = m_pol;
                else                      m_rd = m_dir;
            end
            if (wr_en) begin
                if (reg_idx == 2'd1)      m_out = wr_data;
                else if (reg_idx == 2'd2) m_pol = wr_data;
                else if (reg_idx == 2'd3) m_dir = wr_data;
            end
        end
        #2;
        chk("R3", pin_oe, ~m_dir, "model pin_oe");
        chk("R7", pin_out, m_out, "model pin_out");
        chk("R8", rd_data, m_rd, "model rd_data");
    endtask

    task automatic idle();
        wr_en = 1'b0; rd_en = 1'b0;
        tick();
    endtask

    task automatic wr(logic [1:0] idx, logic [7:0] d);
        reg_idx = idx; wr_data = d; wr_en = 1'b1; rd_en = 1'b0;
        tick();
        wr_en = 1'b0;
    endtask

    task automatic rd(logic [1:0] idx, logic [7:0] exp, string tag);
        reg_idx = idx; rd_en = 1'b1; wr_en = 1'b0;
        tick();
        rd_en = 1'b0;
        chk(tag, rd_data, exp, "read");
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog all actual=%0d expected=%0d", 1, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; wr_en = 1'b0; rd_en = 1'b0;
        reg_idx = 2'd0; wr_data = 8'h00; pin_lvl = 8'h00;
        repeat (3) tick();
        // R1 reset state
        chk("R1", pin_oe,  8'h00, "pin_oe after reset");
        chk("R1", pin_out, 8'hFF, "pin_out after reset");
        chk("R1", rd_data, 8'h00, "rd_data after reset");
        rst = 1'b0;
        rd(2'd1, 8'hFF, "R1");
        rd(2'd2, 8'h00, "R1");
        rd(2'd3, 8'hFF, "R1");

        // R4 input view with and without polarity
        pin_lvl = 8'hA5;
        rd(2'd0, 8'hA5, "R4");
        wr(2'd2, 8'h0F);
        rd(2'd0, 8'hAA, "R4");
        rd(2'd2, 8'h0F, "R2");

        // R7 output write lands next cycle, pins still inputs
        wr(2'd1, 8'h3C);
        chk("R7", pin_out, 8'h3C, "pin_out after write");
        chk("R3", pin_oe,  8'h00, "pin_oe all inputs");

        // R3 direction
        wr(2'd3, 8'hF0);
        chk("R3", pin_oe,  8'h0F, "pin_oe low nibble out");
        chk("R7", pin_out, 8'h3C, "pin_out held");

        // R5 output readback ignores pin; R4 includes output pins
        pin_lvl = 8'h00;
        rd(2'd1, 8'h3C, "R5");
        rd(2'd0, 8'h0F, "R4");

        // R6 write to input view ignored
        wr(2'd0, 8'h55);
        chk("R6", pin_out, 8'h3C, "pin_out after idx0 write");
        chk("R6", pin_oe,  8'h0F, "pin_oe after idx0 write");
        rd(2'd1, 8'h3C, "R6");
        rd(2'd2, 8'h0F, "R6");
        rd(2'd3, 8'hF0, "R6");

        // R8 same-cycle read and write returns old value, then holds
        reg_idx = 2'd1; wr_data = 8'h77; wr_en = 1'b1; rd_en = 1'b1;
        tick();
        wr_en = 1'b0; rd_en = 1'b0;
        chk("R8", rd_data, 8'h3C, "read during write");
        idle(); idle();
        chk("R8", rd_data, 8'h3C, "rd_data held");
        rd(2'd1, 8'h77, "R2");

        // R4 sampled at the read edge only
        pin_lvl = 8'hF0;
        rd(2'd0, 8'hFF, "R4");
        pin_lvl = 8'h00;
        idle();
        chk("R4", rd_data, 8'hFF, "input view not live");

        // R7 value held while input, driven when switched
        wr(2'd3, 8'hFF);
        chk("R3", pin_oe, 8'h00, "all inputs");
        wr(2'd1, 8'h81);
        chk("R7", pin_out, 8'h81, "pin_out while input");
        wr(2'd3, 8'h00);
        chk("R3", pin_oe,  8'hFF, "all outputs");
        chk("R7", pin_out, 8'h81, "stored value driven");

        // R9 reset during operation
        rst = 1'b1;
        tick();
        rst = 1'b0;
        chk("R9", pin_oe,  8'h00, "pin_oe after mid reset");
        chk("R9", pin_out, 8'hFF, "pin_out after mid reset");
        chk("R9", rd_data, 8'h00, "rd_data after mid reset");
        rd(2'd2, 8'h00, "R9");
        rd(2'd3, 8'hFF, "R9");

        // random traffic against the model
        for (int i = 0; i < 400; i++) begin
            reg_idx = 2'($urandom);
            wr_data = 8'($urandom);
            pin_lvl = 8'($urandom);
            wr_en   = 1'($urandom);
            rd_en   = 1'($urandom);
            tick();
        end
        wr_en = 1'b0; rd_en = 1'b0;

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule